// File: doc/BRIEF.md
# Atomic-Access GPIO Port

This block is one 32-pin general-purpose I/O port behind a small register bus. Each pin carries eight configuration bits: ownership (port logic or peripheral), output-driver enable, output value, three function-select bits that are spread across three parallel mux registers, and pull-up and pull-down enables. Software never does read-modify-write. Every configuration register has four addresses: a view alias, a set alias, a clear alias and a toggle alias. A write to the set, clear or toggle alias acts only on the bit positions that are 1 in the written mask.

The port drives a level and an output enable for each pad. When a pin is owned by the port, the level and enable come from its own registers. When it is owned by a peripheral, they come from one of eight peripheral functions, picked by the function-select bits. The port also exports the per-pin function index and a decoded pull mode, so a pad ring can use them.

Pad levels are read back through a two-flop synchronizer, whatever drives the pad. A second read-only view gives the level an open-drain pin would show, where the pin holds its value at 0 and the driver enable is toggled to release or pull the line.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration register reads 0, and pad_oe_o, pull_up_o, pull_dn_o and keeper_o are all 0.
- R2: The address is {register index[5:2], operation[1:0]}. A write with operation 1 (set) makes the masked bits 1 and leaves the other bits unchanged.
- R3: A write with operation 2 (clear) makes the masked bits 0 and leaves the other bits unchanged.
- R4: A write with operation 3 (toggle) inverts the masked bits and leaves the other bits unchanged.
- R5: A write with operation 0 (view) has no effect. A write to register index 8, 9 or 10 to 15 has no effect.
- R6: A read from any of the four operation addresses of a register returns that register's current value in the same cycle. Indices 10 to 15 read 0.
- R7: The register indices are: 0 ownership (1 = port owns the pin), 1 driver enable, 2 output value, 3/4/5 function-select bits 0/1/2, 6 pull-up enable, 7 pull-down enable. The function index of pin p is {reg5[p], reg4[p], reg3[p]}, and it appears at func_sel_o[3p+2:3p].
- R8: While pin p is port-owned, pad_o[p] equals output value bit p and pad_oe_o[p] equals driver enable bit p.
- R9: While pin p is peripheral-owned with function index f, pad_o[p] equals periph_out_i[32f+p] and pad_oe_o[p] equals periph_oe_i[32f+p].
- R10: Pull-up enabled alone sets pull_up_o. Pull-down enabled alone sets pull_dn_o. Both enabled together set only keeper_o.
- R11: Register index 8 returns pin_i delayed by two clock edges.
- R12: Register index 9 returns the inverse of the driver-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 6 | {register index, operation} |
| wdata_i | input | 32 | Write mask |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | 32 | Pad input levels, asynchronous |
| periph_out_i | input | 256 | Peripheral levels, function f pin p at bit 32f+p |
| periph_oe_i | input | 256 | Peripheral enables, same layout |
| pad_o | output | 32 | Level driven to each pad |
| pad_oe_o | output | 32 | Pad driver enable |
| func_sel_o | output | 96 | 3-bit function index per pin |
| pull_up_o | output | 32 | Pull-up mode |
| pull_dn_o | output | 32 | Pull-down mode |
| keeper_o | output | 32 | Bus-keeper mode |

## Verification
A register write takes effect at the clock edge that samples the strobe. Reads, pad outputs, function selects and pull modes are combinational from the registers, so the bench drives at a falling edge and checks at the next falling edge. A change on pin_i reaches index 8 only after the second rising edge. The bench therefore checks that the old value still shows one falling edge after the change and the new value shows one edge later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS  = 32;
  localparam int NUM_FUNC  = 8;
  localparam int FSEL_W    = $clog2(NUM_FUNC);
  localparam int IDX_W     = 4;
  localparam int ADDR_W    = IDX_W + 2;
  localparam int NUM_CFG   = 8;

  typedef enum logic [1:0] {
    OP_VIEW = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_e;

  localparam int IDX_OWN  = 0;
  localparam int IDX_DRV  = 1;
  localparam int IDX_VAL  = 2;
  localparam int IDX_FS0  = 3;
  localparam int IDX_PU   = 6;
  localparam int IDX_PD   = 7;
  localparam int IDX_LVL  = 8;
  localparam int IDX_ODLV = 9;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (wr_i) begin
      unique case (op_i)
        OP_SET:  q_o <= q_o | wdata_i;
        OP_CLR:  q_o <= q_o & ~wdata_i;
        OP_TGL:  q_o <= q_o ^ wdata_i;
        default: q_o <= q_o;
      endcase
    end
  end

  assert_set_hits_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_SET) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));
  assert_clr_hits_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_CLR) |=> ((q_o & $past(wdata_i)) == '0));
  assert_unmasked_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i))));
  assert_view_write_inert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && op_i == OP_VIEW) |=> $stable(q_o));
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [1:0]   fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             fill_q <= '0;
    else if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
  end

  assert_two_stage_delay_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int N  = 32,
  parameter int NF = 8,
  localparam int FW = $clog2(NF)
) (
  input  logic [N-1:0]    own_i,
  input  logic [N-1:0]    drv_i,
  input  logic [N-1:0]    val_i,
  input  logic [N-1:0]    fs_i [FW],
  input  logic [NF*N-1:0] periph_out_i,
  input  logic [NF*N-1:0] periph_oe_i,
  output logic [N-1:0]    pad_o,
  output logic [N-1:0]    pad_oe_o,
  output logic [FW*N-1:0] func_sel_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic [FW-1:0] fsel;
    logic [NF-1:0] fout, foe;
    for (genvar b = 0; b < FW; b++) begin : g_bit
      assign fsel[b] = fs_i[b][p];
    end
    for (genvar f = 0; f < NF; f++) begin : g_fn
      assign fout[f] = periph_out_i[f*N+p];
      assign foe[f]  = periph_oe_i[f*N+p];
    end
    assign func_sel_o[p*FW +: FW] = fsel;
    assign pad_o[p]    = own_i[p] ? val_i[p] : fout[fsel];
    assign pad_oe_o[p] = own_i[p] ? drv_i[p] : foe[fsel];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int N  = gpio_pkg::NUM_PINS,
  parameter int NF = gpio_pkg::NUM_FUNC,
  localparam int FW = $clog2(NF),
  localparam int AW = gpio_pkg::ADDR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N-1:0]    wdata_i,
  output logic [N-1:0]    rdata_o,
  input  logic [N-1:0]    pin_i,
  input  logic [NF*N-1:0] periph_out_i,
  input  logic [NF*N-1:0] periph_oe_i,
  output logic [N-1:0]    pad_o,
  output logic [N-1:0]    pad_oe_o,
  output logic [FW*N-1:0] func_sel_o,
  output logic [N-1:0]    pull_up_o,
  output logic [N-1:0]    pull_dn_o,
  output logic [N-1:0]    keeper_o
);
  logic [IDX_W-1:0] idx;
  alias_op_e        op;
  logic [N-1:0]     cfg_q [NUM_CFG];
  logic [N-1:0]     fs_q  [FW];
  logic [N-1:0]     lvl_q;

  assign idx = addr_i[AW-1:2];
  assign op  = alias_op_e'(addr_i[1:0]);

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    gpio_alias_reg #(.W(N)) u_reg (
      .clk_i, .rst_ni,
      .wr_i   (wr_en_i && (idx == IDX_W'(r))),
      .op_i   (op),
      .wdata_i,
      .q_o    (cfg_q[r])
    );
  end

  for (genvar b = 0; b < FW; b++) begin : g_fs
    assign fs_q[b] = cfg_q[IDX_FS0+b];
  end

  gpio_sync #(.W(N)) u_sync (.clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl_q));

  gpio_pin_mux #(.N(N), .NF(NF)) u_mux (
    .own_i(cfg_q[IDX_OWN]), .drv_i(cfg_q[IDX_DRV]), .val_i(cfg_q[IDX_VAL]),
    .fs_i(fs_q), .periph_out_i, .periph_oe_i,
    .pad_o, .pad_oe_o, .func_sel_o
  );

  assign pull_up_o = cfg_q[IDX_PU] & ~cfg_q[IDX_PD];
  assign pull_dn_o = cfg_q[IDX_PD] & ~cfg_q[IDX_PU];
  assign keeper_o  = cfg_q[IDX_PU] &  cfg_q[IDX_PD];

  always_comb begin
    rdata_o = '0;
    if (idx < IDX_W'(NUM_CFG))       rdata_o = cfg_q[idx[$clog2(NUM_CFG)-1:0]];
    else if (idx == IDX_W'(IDX_LVL))  rdata_o = lvl_q;
    else if (idx == IDX_W'(IDX_ODLV)) rdata_o = ~cfg_q[IDX_DRV];
  end

  assert_pull_modes_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_up_o & pull_dn_o) | (pull_up_o & keeper_o) | (pull_dn_o & keeper_o)) == '0);
  assert_od_view_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1:2] == IDX_W'(IDX_ODLV)) |-> ((rdata_o ^ pad_oe_o) & cfg_q[IDX_OWN]) == cfg_q[IDX_OWN]);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pad_oe_o == '0 && keeper_o == '0));
endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
  localparam int N = 32;
  localparam int NF = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [5:0] addr = '0;
  logic [N-1:0] wdata = '0, pin = '0;
  logic [NF*N-1:0] pout = '0, poe = '0;
  logic [N-1:0] rdata, pad, pad_oe, pu, pd, kp;
  logic [3*N-1:0] fsel;

  always #10 clk = ~clk;

  gpio_port_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .periph_out_i(pout), .periph_oe_i(poe),
    .pad_o(pad), .pad_oe_o(pad_oe), .func_sel_o(fsel),
    .pull_up_o(pu), .pull_dn_o(pd), .keeper_o(kp)
  );

  int vec = 0, bad = 0;
  logic [N-1:0] m [8];
  logic [31:0] seed = 32'h1234_abcd;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int op, logic [N-1:0] d);
    @(negedge clk);
    addr = 6'((idx << 2) | op); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (idx < 8) case (op)
      1: m[idx] = m[idx] | d;
      2: m[idx] = m[idx] & ~d;
      3: m[idx] = m[idx] ^ d;
      default: ;
    endcase
  endtask

  task automatic rd_all(string req);
    for (int i = 0; i < 8; i++)
      for (int op = 0; op < 4; op++) begin
        addr = 6'((i << 2) | op); #1;
        chk(req, rdata, m[i]);
      end
    addr = 6'(9 << 2); #1; chk("R12", rdata, ~m[1]);
    for (int i = 10; i < 16; i++) begin
      addr = 6'(i << 2); #1; chk("R6", rdata, '0);
    end
  endtask

  task automatic chk_pins();
    logic [N-1:0] ep, eo, eu, ed, ek;
    logic [3*N-1:0] ef;
    for (int p = 0; p < N; p++) begin
      int f = {m[5][p], m[4][p], m[3][p]};
      ef[3*p +: 3] = 3'(f);
      ep[p] = m[0][p] ? m[2][p] : pout[f*N+p];
      eo[p] = m[0][p] ? m[1][p] : poe[f*N+p];
      eu[p] = m[6][p] & ~m[7][p];
      ed[p] = m[7][p] & ~m[6][p];
      ek[p] = m[6][p] & m[7][p];
    end
    chk("R8/R9 pad", pad, ep);
    chk("R8/R9 oe", pad_oe, eo);
    for (int k = 0; k < 3; k++) chk("R7", fsel[k*N +: N], ef[k*N +: N]);
    chk("R10 up", pu, eu); chk("R10 dn", pd, ed); chk("R10 keep", kp, ek);
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_all("R1");
    chk_pins();
    chk("R1 oe", pad_oe, '0);

    // R2/R3/R4 sweeps on every register
    for (int it = 0; it < 40; it++)
      for (int i = 0; i < 8; i++) begin
        seed = nxt(seed);
        wr(i, 1 + (it % 3), seed);
        addr = 6'((i << 2) | (1 + it % 3)); #1;
        chk(it % 3 == 0 ? "R2" : (it % 3 == 1 ? "R3" : "R4"), rdata, m[i]);
      end
    rd_all("R6");

    // R5: view writes and read-only indices ignored
    for (int i = 0; i < 16; i++) wr(i, 0, 32'hffff_ffff);
    for (int i = 8; i < 16; i++) wr(i, 1 + i % 3, 32'ha5a5_5a5a);
    rd_all("R5");
    chk_pins();

    // R7/R8/R9: function sweep and ownership mixes
    for (int p = 0; p < N; p++) begin
      pout[p*NF +: NF] = 8'(p * 37 + 11);
      poe[p*NF +: NF]  = 8'(p * 91 + 5);
    end
    for (int i = 0; i < 8; i++) wr(i, 2, '1);
    for (int f = 0; f < 8; f++) begin
      for (int b = 0; b < 3; b++) wr(3 + b, f[b] ? 1 : 2, '1);
      chk_pins();
      pout = ~pout; #1; chk_pins();
    end
    for (int it = 0; it < 24; it++) begin
      seed = nxt(seed); wr(it % 8, 3, seed);
      seed = nxt(seed); poe = {8{seed}}; #1;
      chk_pins();
    end

    // R10 all four pull combinations
    for (int c = 0; c < 4; c++) begin
      wr(6, c[0] ? 1 : 2, 32'h0f0f_00ff);
      wr(7, c[1] ? 1 : 2, 32'h00ff_0f0f);
      chk_pins();
    end

    // R11 two-edge synchronizer
    for (int it = 0; it < 10; it++) begin
      logic [N-1:0] old;
      addr = 6'(8 << 2);
      @(negedge clk); old = pin;
      seed = nxt(seed); pin = seed;
      @(negedge clk); #1; chk("R11 hold", rdata, old);
      @(negedge clk); #1; chk("R11 new", rdata, pin);
    end

    // R12 open-drain emulation: value held 0, driver toggled
    wr(0, 1, '1); wr(2, 2, '1);
    for (int it = 0; it < 4; it++) begin
      wr(1, 3, 32'h8000_0001 << it);
      addr = 6'(9 << 2); #1; chk("R12", rdata, ~m[1]);
      chk("R12 pad", pad, '0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule